// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block is the serial back end of a transmit-only audio port that always acts as bus master. It runs from a master clock and derives a bit clock and a word-select clock itself. The bit-clock rate comes from a programmed ratio, and each half period of the bit clock lasts `ratio + 2` master clocks. Each frame carries a left slot and then a right slot. For each slot the block pulls one word from an upstream show-ahead FIFO and shifts it out most significant bit first.

When transmit is enabled, the block first plays one frame of silence and only then starts taking queued words. If the FIFO is empty at a slot boundary, the slot is filled with zeros and the clocks keep running. When transmit is disabled, the block completes the current frame and then parks all three serial outputs low. The slot width, the ratio and the justification mode are captured at the moment transmission starts.

Top module: `i2sTxSerializer`

## Requirements
- R1: Out of reset and whenever the block is idle, `bclk`, `ws` and `sdata` are low and `fifoPop` is never asserted. A high `txEnable` seen while idle starts transmission on the next master clock edge.
- R2: While transmitting, `bclk` holds each level for exactly `ratio + 2` master clocks, so one bit period is `2*(ratio+2)` master clocks.
- R3: The first frame after a start is all zeros, begins with the left slot, and pops nothing from the FIFO.
- R4: `ws` is low during the left slot and high during the right slot. Each slot is 32 bit periods when `slotRes` equals 32, and 16 bit periods for any other value.
- R5: With `leftJustify` low (standard I2S format), a slot word's MSB appears one bit period after `ws` changes. The LSB of the right word therefore appears in the first bit period of the next frame. `sdata` and `ws` change only when `bclk` falls.
- R6: With `leftJustify` high, a slot word's MSB appears in the same bit period in which `ws` changes.
- R7: After the zero frame, each slot pops exactly one FIFO word, left slot first. Of each word, only bits `[res-1:0]` are sent, highest first.
- R8: A slot that begins while `fifoValid` is low is sent as zeros without a pop, and the bit clock keeps running.
- R9: When `txEnable` is low at the end of a frame, the block stops after that frame's last bit period, with no further bit periods. Enabling again restarts with a zero frame.
- R10: Changes to `ratio`, `slotRes` or `leftJustify` while transmitting have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmit enable |
| leftJustify | input | 1 | 1: MSB aligned with word select; 0: standard one-bit delay |
| slotRes | input | 6 | Slot resolution; 32 selects 32-bit slots, any other value 16 |
| ratio | input | 8 | Bit-clock ratio; half period is ratio+2 master clocks |
| fifoValid | input | 1 | Upstream FIFO holds a word |
| fifoData | input | 32 | Word at the FIFO head |
| fifoPop | output | 1 | Consume the FIFO head at this clock edge |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, low for left |
| sdata | output | 1 | Serial data |

## Verification
The assertions assume a show-ahead FIFO: `fifoData` is meaningful whenever `fifoValid` is high, and the head advances only on a pop. The bench models exactly that, with a word array indexed by the pops it has counted. The bench drives `txEnable` only while the block is idle, or well inside the last frame it wants played, so the stop point is defined. Configuration inputs are changed only after a start has captured them, and the check of R10 depends on this.

// File: rtl/i2sTxPkg.sv
package i2sTxPkg;
  // Strobes from the sequencing control to the shift datapath.
  typedef struct packed {
    logic start;     // begin a run: clear the shifter
    logic advance;   // a bit period ends on this edge
    logic load;      // the next bit period opens a slot
    logic takeWord;  // the opened slot takes the FIFO head
    logic halt;      // run ends on this edge
  } txStrobe_t;
endpackage

// File: rtl/i2sTxBitClock.sv
module i2sTxBitClock #(
  parameter int RATIO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             restart,
  input  logic [RATIO_W:0] halfLen,
  output logic             bclk,
  output logic             fallTick
);
  logic [RATIO_W:0] cnt;
  logic             terminal;

  assign terminal = (cnt == halfLen - (RATIO_W+1)'(1));
  assign fallTick = run && terminal && bclk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (restart || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (terminal) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + (RATIO_W+1)'(1);
    end
  end
endmodule

// File: rtl/i2sTxCtrl.sv
module i2sTxCtrl import i2sTxPkg::*; #(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic               leftJustify,
  input  logic [RES_W-1:0]   slotRes,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               fifoValid,
  input  logic               fallTick,
  output txStrobe_t          strobe,
  output logic               fifoPop,
  output logic               running,
  output logic               ws,
  output logic               cfgLong,
  output logic               cfgLj,
  output logic [RATIO_W:0]   halfLen
);
  localparam int IDX_W = $clog2(2*DATA_W);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(2*DATA_W-1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(2*SHORT_W-1);
  localparam logic [IDX_W-1:0] SLOT_LONG  = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] SLOT_SHORT = IDX_W'(SHORT_W);

  logic [IDX_W-1:0] bitIdx, nextIdx, slotLen;
  logic zeroFrame, frameLast, stopNow, slotEdge, stillZero;

  assign slotLen   = cfgLong ? SLOT_LONG : SLOT_SHORT;
  assign frameLast = (bitIdx == (cfgLong ? LAST_LONG : LAST_SHORT));
  assign nextIdx   = frameLast ? '0 : bitIdx + IDX_W'(1);
  assign slotEdge  = (nextIdx == '0) || (nextIdx == slotLen);
  assign stillZero = zeroFrame && !frameLast;
  assign stopNow   = fallTick && frameLast && !txEnable;

  always_comb begin
    strobe.start    = !running && txEnable;
    strobe.advance  = running && fallTick && !stopNow;
    strobe.load     = strobe.advance && slotEdge;
    strobe.takeWord = strobe.load && !stillZero && fifoValid;
    strobe.halt     = running && stopNow;
  end
  assign fifoPop = strobe.takeWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      bitIdx    <= '0;
      zeroFrame <= 1'b0;
      ws        <= 1'b0;
      cfgLong   <= 1'b0;
      cfgLj     <= 1'b0;
      halfLen   <= (RATIO_W+1)'(2);
    end else if (strobe.start) begin
      running   <= 1'b1;
      bitIdx    <= '0;
      zeroFrame <= 1'b1;
      ws        <= 1'b0;
      cfgLong   <= (slotRes == RES_W'(DATA_W));
      cfgLj     <= leftJustify;
      halfLen   <= {1'b0, ratio} + (RATIO_W+1)'(2);
    end else if (strobe.halt) begin
      running   <= 1'b0;
      bitIdx    <= '0;
      ws        <= 1'b0;
    end else if (strobe.advance) begin
      bitIdx <= nextIdx;
      ws     <= (nextIdx >= slotLen);
      if (frameLast) zeroFrame <= 1'b0;
    end
  end
endmodule

// File: rtl/i2sTxShift.sv
module i2sTxShift import i2sTxPkg::*; #(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              cfgLong,
  input  logic              cfgLj,
  input  logic [DATA_W-1:0] fifoData,
  output logic              sdata
);
  logic [DATA_W-1:0] shiftQ, shortWord, loadWord, nextShift;

  generate
    if (SHORT_W < DATA_W) begin : g_pad
      assign shortWord = {fifoData[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};
    end else begin : g_same
      assign shortWord = fifoData;
    end
  endgenerate

  assign loadWord  = strobe.takeWord ? (cfgLong ? fifoData : shortWord) : '0;
  assign nextShift = strobe.load ? loadWord : (shiftQ << 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      sdata  <= 1'b0;
    end else if (strobe.start || strobe.halt) begin
      shiftQ <= '0;
      sdata  <= 1'b0;
    end else if (strobe.advance) begin
      shiftQ <= nextShift;
      // standard format replays the bit that was just leaving the MSB
      sdata  <= cfgLj ? nextShift[DATA_W-1] : shiftQ[DATA_W-1];
    end
  end
endmodule

// File: rtl/i2sTxSerializer.sv
module i2sTxSerializer import i2sTxPkg::*; #(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic               leftJustify,
  input  logic [RES_W-1:0]   slotRes,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               fifoValid,
  input  logic [DATA_W-1:0]  fifoData,
  output logic               fifoPop,
  output logic               bclk,
  output logic               ws,
  output logic               sdata
);
  txStrobe_t        strobe;
  logic             active, fallTick, cfgLong, cfgLj;
  logic [RATIO_W:0] halfLen;

  i2sTxCtrl #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .RATIO_W(RATIO_W), .RES_W(RES_W)) uCtrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .leftJustify(leftJustify),
    .slotRes(slotRes), .ratio(ratio), .fifoValid(fifoValid), .fallTick(fallTick),
    .strobe(strobe), .fifoPop(fifoPop), .running(active), .ws(ws),
    .cfgLong(cfgLong), .cfgLj(cfgLj), .halfLen(halfLen)
  );

  i2sTxBitClock #(.RATIO_W(RATIO_W)) uBitClk (
    .clk(clk), .rstN(rstN), .run(active), .restart(strobe.start),
    .halfLen(halfLen), .bclk(bclk), .fallTick(fallTick)
  );

  i2sTxShift #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) uShift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgLong(cfgLong), .cfgLj(cfgLj),
    .fifoData(fifoData), .sdata(sdata)
  );
endmodule

// File: rtl/i2sTxChecker.sv
module i2sTxChecker (
  input logic clk,
  input logic rstN,
  input logic active,
  input logic fifoValid,
  input logic fifoPop,
  input logic bclk,
  input logic ws,
  input logic sdata
);
  // R1: idle keeps the bus quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!bclk && !ws && !sdata && !fifoPop));

  // R3: a run opens low on every line, left slot first
  p_start_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (!bclk && !ws && !sdata));

  // R5: lines hold while the bit clock is high
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bclk && $past(bclk)) |-> ($stable(sdata) && $stable(ws)));

  // R4: word select only moves on a bit-clock fall
  p_ws_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ws != $past(ws)) |-> (!bclk && $past(bclk)));

  // R8 / R7: pops only with data, only on the fall edge of a running clock
  p_pop_with_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (fifoValid && bclk && active));
endmodule

bind i2sTxSerializer i2sTxChecker uChk (
  .clk(clk), .rstN(rstN), .active(active), .fifoValid(fifoValid),
  .fifoPop(fifoPop), .bclk(bclk), .ws(ws), .sdata(sdata)
);

// File: tb/tb_i2sTxSerializer.sv
`timescale 1ns/1ps
module tb_i2sTxSerializer;
  logic clk = 1'b0;
  logic rstN;
  logic txEnable, leftJustify, fifoValid, fifoPop, bclk, ws, sdata;
  logic [5:0]  slotRes;
  logic [7:0]  ratio;
  logic [31:0] fifoData;

  always #2.5 clk = ~clk;

  i2sTxSerializer dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .leftJustify(leftJustify),
    .slotRes(slotRes), .ratio(ratio), .fifoValid(fifoValid), .fifoData(fifoData),
    .fifoPop(fifoPop), .bclk(bclk), .ws(ws), .sdata(sdata)
  );

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // show-ahead FIFO model
  logic [31:0] mem [0:15];
  int fifoCount = 0;
  int runBase = 0;
  int popTotal = 0;
  int headIdx;
  always_comb begin
    headIdx   = popTotal - runBase;
    fifoValid = (headIdx < fifoCount);
    fifoData  = fifoValid ? mem[headIdx[3:0]] : 32'hDEAD_BEEF;
  end
  always @(posedge clk) if (fifoPop) popTotal <= popTotal + 1;

  // receiver: samples on bit-clock rises, measures half periods
  bit  recWs [0:1023];
  bit  recSd [0:1023];
  int  recCount = 0;
  int  halfErr = 0;
  int  halfExp = 2;
  bit  measuring = 1'b0;
  bit  sawEdge = 1'b0;
  int  halfCnt = 0;
  logic prevB = 1'b0;
  always @(negedge clk) begin
    halfCnt++;
    if (!measuring) sawEdge = 1'b0;
    if (bclk !== prevB) begin
      if (measuring && sawEdge && halfCnt != halfExp) halfErr++;
      sawEdge = measuring;
      halfCnt = 0;
      if (bclk === 1'b1) begin
        recWs[recCount % 1024] = ws;
        recSd[recCount % 1024] = sdata;
        recCount++;
      end
    end
    prevB = bclk;
  end

  function automatic bit expBit(input int lj, input int res, input int n, input int k,
                                output bit wsE, output bit ljB);
    int fr, b, slot, bi, s;
    logic [31:0] word;
    fr   = k / (2*res);
    b    = k % (2*res);
    slot = b / res;
    bi   = b % res;
    s    = (fr - 1) * 2 + slot;
    word = (fr == 0 || s >= n) ? 32'h0 : mem[s];
    wsE  = slot[0];
    ljB  = word[res-1-bi];
    return (fr == 0 || s >= n);
  endfunction

  task automatic runCase(input int r, input int rs, input bit lj, input int n,
                         input int f, input bit scramble);
    int res, rb, hb, want, pops, mism, snap;
    bit prevLj, wsE, ljB, empty, sdE;
    string tag;
    res = (rs == 32) ? 32 : 16;
    measuring = 1'b0;
    @(negedge clk);
    ratio = 8'(r); slotRes = 6'(rs); leftJustify = lj;
    fifoCount = 0;
    for (int i = 0; i < 16; i++) mem[i] = $urandom;
    runBase = popTotal;
    fifoCount = n;
    halfExp = r + 2;
    rb = recCount; hb = halfErr;
    @(negedge clk);
    measuring = 1'b1;
    txEnable = 1'b1;
    repeat (3) @(negedge clk);
    if (scramble) begin
      ratio = 8'($urandom);
      slotRes = (res == 32) ? 6'd16 : 6'd32;
      leftJustify = !lj;
    end
    while (recCount - rb < (f-1)*2*res + 3) @(negedge clk);
    txEnable = 1'b0;
    while (recCount - rb < f*2*res) @(negedge clk);
    repeat (r + 6) @(negedge clk);
    // R9: parked low after the last frame
    check(bclk == 0 && ws == 0 && sdata == 0, "R9", "lines low after stop",
          {bclk, ws, sdata}, 0);
    snap = popTotal;
    repeat (4*(r+2) + 20) @(negedge clk);
    check(recCount - rb == f*2*res, "R9", "bit periods played", recCount - rb, f*2*res);
    check(popTotal == snap, "R1", "no pop while idle", popTotal - snap, 0);
    pops = popTotal - runBase;
    want = (n < 2*(f-1)) ? n : 2*(f-1);
    check(pops == want, (n < 2*(f-1)) ? "R8" : "R7", "words popped", pops, want);
    check(halfErr - hb == 0, "R2", "half periods off", halfErr - hb, 0);
    mism = 0;
    prevLj = 1'b0;
    for (int k = 0; k < f*2*res; k++) begin
      empty = expBit(lj, res, n, k, wsE, ljB);
      sdE = lj ? ljB : prevLj;
      prevLj = ljB;
      check(recWs[(rb+k)%1024] == wsE, "R4", $sformatf("ws bit %0d", k),
            recWs[(rb+k)%1024], wsE);
      tag = (k < 2*res) ? "R3" : (empty ? "R8" : (lj ? "R6" : "R5"));
      if (recSd[(rb+k)%1024] != sdE) mism++;
      check(recSd[(rb+k)%1024] == sdE, tag, $sformatf("sdata bit %0d", k),
            recSd[(rb+k)%1024], sdE);
    end
    if (scramble) check(mism == 0, "R10", "bits off after config change", mism, 0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rstN = 1'b0; txEnable = 1'b0; leftJustify = 1'b0; slotRes = 6'd16; ratio = 8'd0;
    repeat (4) @(negedge clk);
    check(bclk == 0 && ws == 0 && sdata == 0 && fifoPop == 0, "R1", "lines in reset",
          {bclk, ws, sdata, fifoPop}, 0);
    rstN = 1'b1;
    fifoCount = 3;
    repeat (20) @(negedge clk);
    check(bclk == 0 && ws == 0 && sdata == 0, "R1", "idle after reset", {bclk, ws, sdata}, 0);
    check(popTotal == 0, "R1", "pops while disabled", popTotal, 0);
    fifoCount = 0;
    // directed corners
    runCase(0, 32, 1'b0, 0, 2, 1'b0);    // R8 all slots starve, fastest clock
    runCase(255, 24, 1'b1, 2, 2, 1'b0);  // R2 slowest clock, R4 non-32 value gives 16
    runCase(3, 16, 1'b0, 8, 4, 1'b0);    // R7 more words than slots
    runCase(1, 32, 1'b1, 3, 3, 1'b1);    // R10 config moved mid-run, partial underrun
    // constrained random runs
    for (int i = 0; i < 8; i++) begin
      int r, f, n;
      bit lj, long;
      r = $urandom_range(0, 7);
      f = $urandom_range(2, 4);
      n = $urandom_range(0, 7);
      lj = 1'($urandom);
      long = 1'($urandom);
      runCase(r, long ? 32 : 16, lj, n, f, 1'($urandom));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule